// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Protection Controller

This block holds the control state of a small serial EEPROM: the write-enable latch, the two block-protect bits and the self-timed programming cycle. A serial front end decodes instructions and hands the block single-cycle strobes. These strobes set or clear the enable latch, commit a status write with two new protect bits, or commit a page write with a page index. The block also watches an active-low write-protect pin. It decides whether each commit is allowed. An accepted commit starts a programming interval whose length is fixed by a parameter. A rejected commit is dropped without any effect on the array.

The block presents an 8-bit status byte that can be read at any moment, a busy flag, and a one-cycle write strobe with the page index for the array. The protect bits split the address space into quarters and guard the upper quarter, the upper half or the whole array. The array is always readable, because protection only affects writes. When a status write is running, the status byte still shows the old protect bits. The new bits appear in the same cycle that the busy bit reads 0.

Top module: `wpc_top`

## Requirements
- R1: The status byte is {4'b1111, bp[1:0], wel, wip}, with bit 0 = wip and bit 1 = wel. After reset it reads 8'hF0 when BP_INIT is 2'b00.
- R2: A set-enable strobe sets wel in the next cycle, and a clear-enable strobe clears it. When both arrive in the same cycle, the clear wins. Both strobes are ignored while wip is 1.
- R3: A commit is accepted only when wel is 1, wip is 0 and wp_n_i is 1. When a commit is accepted, wip reads 1 from the next cycle for exactly PROG_CYCLES cycles.
- R4: A commit that is not accepted leaves wip unchanged, raises no array strobe, keeps the held page index, and clears wel in the next cycle.
- R5: A page write is rejected when its page lies in a protected range. The codes are: 00 protects nothing, 01 protects addresses 300h–3FFh, 10 protects 200h–3FFh, and 11 protects the whole array. Page p covers addresses p*16 to p*16+15. Status writes are never subject to this range check.
- R6: An accepted page write raises arr_wr_o for exactly one cycle, the cycle after the commit. arr_page_o shows the page index from that cycle until the next accepted page write.
- R7: While a status write is programming, bits 3:2 of the status byte keep the old protect code. The new code appears in the first cycle in which wip reads 0.
- R8: wel reads 0 in the first cycle after a programming interval ends.
- R9: When a status commit and a page commit arrive in the same cycle, only the status commit is evaluated. The page commit is dropped.
- R10: Reset returns the protect bits to BP_INIT and clears wel and wip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wen_set_i | input | 1 | Strobe that sets the write-enable latch |
| wen_clr_i | input | 1 | Strobe that clears the write-enable latch |
| sr_commit_i | input | 1 | Status-write commit strobe |
| sr_bp_i | input | 2 | New protect code that goes with sr_commit_i |
| pg_commit_i | input | 1 | Page-write commit strobe |
| pg_page_i | input | PAGE_W | Page index that goes with pg_commit_i |
| wp_n_i | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Programming interval in progress |
| arr_wr_o | output | 1 | One-cycle array write strobe |
| arr_page_o | output | PAGE_W | Page index for the array write |

## Verification
Every strobe takes effect on the clock edge where it is sampled. So the enable bit, a rejection and the array strobe all show up on the ports one cycle after the strobe. Busy then stays high for PROG_CYCLES cycles, and the new protect bits and the cleared latch appear together in the first cycle where busy reads 0. A behavioural model in the bench uses these same latencies: a remaining-cycle counter and plain integers, updated on the rising edge. The ports are compared with the model on every falling edge. Directed checks also sample one falling edge after each strobe, and they count the busy cycles until wip drops.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int BP_W = 2;

    typedef enum logic [0:0] {
        PROG_ARRAY  = 1'b0,
        PROG_STATUS = 1'b1
    } prog_kind_e;

    function automatic logic [7:0] pack_status(input logic [BP_W-1:0] bp,
                                               input logic wel,
                                               input logic wip);
        return {4'b1111, bp, wel, wip};
    endfunction

endpackage

// File: rtl/wpc_protect_map.sv
module wpc_protect_map #(
    parameter int PAGE_W = 6
) (
    input  logic [wpc_pkg::BP_W-1:0] bp_i,
    input  logic [PAGE_W-1:0]        page_i,
    output logic                     prot_o
);
    import wpc_pkg::*;

    logic [1:0] hi_quarter;
    logic [1:0] first_quarter;

    // Highest quarter of the address space touched by the page
    generate
        if (PAGE_W >= 2) begin : g_small_page
            assign hi_quarter = page_i[PAGE_W-1 -: 2];
        end else if (PAGE_W == 1) begin : g_half_page
            assign hi_quarter = {page_i[0], 1'b1};
        end else begin : g_whole_page
            assign hi_quarter = 2'b11;
        end
    endgenerate

    always_comb begin
        unique case (bp_i)
            2'b01:   first_quarter = 2'd3;
            2'b10:   first_quarter = 2'd2;
            default: first_quarter = 2'd0;
        endcase
    end

    assign prot_o = (bp_i != 2'b00) && (hi_quarter >= first_quarter);

    always_comb begin
        if (bp_i == 2'b11) begin
            AST_FULL_CODE_GUARDS_ALL: assert (prot_o); // R5
        end
        if (bp_i == 2'b00) begin
            AST_ZERO_CODE_GUARDS_NONE: assert (!prot_o); // R5
        end
    end

endmodule

// File: rtl/wpc_cmd_gate.sv
module wpc_cmd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_commit_i,
    input  logic pg_commit_i,
    input  logic wel_i,
    input  logic busy_i,
    input  logic wp_n_i,
    input  logic prot_i,
    output logic acc_sr_o,
    output logic acc_pg_o,
    output logic reject_o
);
    logic any_commit;
    logic allow;

    always_comb begin
        any_commit = sr_commit_i | pg_commit_i;
        allow      = wel_i & ~busy_i & wp_n_i;
        acc_sr_o   = sr_commit_i & allow;
        acc_pg_o   = pg_commit_i & ~sr_commit_i & allow & ~prot_i;
        reject_o   = any_commit & ~(acc_sr_o | acc_pg_o);
    end

    AST_GATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_sr_o, acc_pg_o, reject_o})); // R9

    AST_STATUS_BEATS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_commit_i && pg_commit_i) |-> !acc_pg_o); // R9

endmodule

// File: rtl/wpc_prog_timer.sv
module wpc_prog_timer #(
    parameter int PROG_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = (PROG_CYCLES < 2) ? 1 : $clog2(PROG_CYCLES);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign busy_o = tmr_q.busy;
    assign done_o = tmr_q.busy && (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    AST_DONE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o); // R3

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R3

    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o); // R3

endmodule

// File: rtl/wpc_top.sv
module wpc_top #(
    parameter int         ADDR_W          = 10,
    parameter int         PAGE_BYTES_LOG2 = 4,
    parameter int         PROG_CYCLES     = 20,
    parameter logic [1:0] BP_INIT         = 2'b00,
    localparam int        PAGE_W          = ADDR_W - PAGE_BYTES_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen_set_i,
    input  logic              wen_clr_i,
    input  logic              sr_commit_i,
    input  logic [1:0]        sr_bp_i,
    input  logic              pg_commit_i,
    input  logic [PAGE_W-1:0] pg_page_i,
    input  logic              wp_n_i,
    output logic [7:0]        status_o,
    output logic              busy_o,
    output logic              arr_wr_o,
    output logic [PAGE_W-1:0] arr_page_o
);
    import wpc_pkg::*;

    typedef struct packed {
        logic              wel;
        logic [BP_W-1:0]   bp;
        logic [BP_W-1:0]   bp_pend;
        prog_kind_e        kind;
        logic              stb;
        logic [PAGE_W-1:0] page;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic busy;
    logic done;
    logic prot;
    logic acc_sr;
    logic acc_pg;
    logic rej;
    logic start;

    wpc_protect_map #(.PAGE_W(PAGE_W)) u_map (
        .bp_i   (ctl_q.bp),
        .page_i (pg_page_i),
        .prot_o (prot)
    );

    wpc_cmd_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .sr_commit_i (sr_commit_i),
        .pg_commit_i (pg_commit_i),
        .wel_i       (ctl_q.wel),
        .busy_i      (busy),
        .wp_n_i      (wp_n_i),
        .prot_i      (prot),
        .acc_sr_o    (acc_sr),
        .acc_pg_o    (acc_pg),
        .reject_o    (rej)
    );

    assign start = acc_sr | acc_pg;

    wpc_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy),
        .done_o  (done)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.stb = 1'b0;
        if (done) begin
            ctl_d.wel = 1'b0;
            if (ctl_q.kind == PROG_STATUS) begin
                ctl_d.bp = ctl_q.bp_pend;
            end
        end
        if (acc_sr) begin
            ctl_d.kind    = PROG_STATUS;
            ctl_d.bp_pend = sr_bp_i;
        end else if (acc_pg) begin
            ctl_d.kind = PROG_ARRAY;
            ctl_d.stb  = 1'b1;
            ctl_d.page = pg_page_i;
        end else if (rej) begin
            ctl_d.wel = 1'b0;
        end else if (!busy) begin
            if (wen_clr_i) begin
                ctl_d.wel = 1'b0;
            end else if (wen_set_i) begin
                ctl_d.wel = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q         <= '0;
            ctl_q.bp      <= BP_INIT;
            ctl_q.bp_pend <= BP_INIT;
            ctl_q.kind    <= PROG_ARRAY;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign status_o   = pack_status(ctl_q.bp, ctl_q.wel, busy);
    assign busy_o     = busy;
    assign arr_wr_o   = ctl_q.stb;
    assign arr_page_o = ctl_q.page;

    AST_STROBE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_o |-> busy_o); // R6

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_o |=> !arr_wr_o); // R6

    AST_NO_WEL_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        ((sr_commit_i || pg_commit_i) && !ctl_q.wel && !busy_o) |=> !busy_o); // R3

    AST_WP_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        ((sr_commit_i || pg_commit_i) && !wp_n_i && !busy_o) |=> !busy_o); // R3

    AST_REJECT_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        rej |=> !status_o[1]); // R4

    AST_BP_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_o) && busy_o) |-> $stable(status_o[3:2])); // R7

    AST_WEL_LOW_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !status_o[1]); // R8

    AST_PAGE_HELD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_wr_o |-> $stable(arr_page_o)); // R6

endmodule

// File: tb/wpc_top_tb_top.sv
module wpc_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 8;
    localparam int PW         = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wen_set = 1'b0;
    logic          wen_clr = 1'b0;
    logic          sr_commit = 1'b0;
    logic [1:0]    sr_bp = 2'b00;
    logic          pg_commit = 1'b0;
    logic [PW-1:0] pg_page = '0;
    logic          wp_n = 1'b1;
    logic [7:0]    status;
    logic          busy;
    logic          arr_wr;
    logic [PW-1:0] arr_page;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wpc_top #(.ADDR_W(10), .PAGE_BYTES_LOG2(4), .PROG_CYCLES(PROG), .BP_INIT(2'b00)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wen_set_i   (wen_set),
        .wen_clr_i   (wen_clr),
        .sr_commit_i (sr_commit),
        .sr_bp_i     (sr_bp),
        .pg_commit_i (pg_commit),
        .pg_page_i   (pg_page),
        .wp_n_i      (wp_n),
        .status_o    (status),
        .busy_o      (busy),
        .arr_wr_o    (arr_wr),
        .arr_page_o  (arr_page)
    );

    // Behavioural reference model
    int m_wel = 0, m_bp = 0, m_pend = 0, m_left = 0, m_is_sr = 0, m_stb = 0, m_page = 0;

    function automatic int guarded(int bp, int page);
        int a = page * 16;
        if (bp == 1) return (a >= 'h300) ? 1 : 0;
        if (bp == 2) return (a >= 'h200) ? 1 : 0;
        if (bp == 3) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wel = 0; m_bp = 0; m_pend = 0; m_left = 0; m_stb = 0; m_page = 0; m_is_sr = 0;
        end else begin
            int was_busy;
            int ok;
            was_busy = (m_left > 0) ? 1 : 0;
            m_stb = 0;
            if (was_busy != 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_wel = 0;
                    if (m_is_sr != 0) m_bp = m_pend;
                end
            end
            if (sr_commit || pg_commit) begin
                ok = (m_wel != 0 && was_busy == 0 && wp_n) ? 1 : 0;
                if (!sr_commit && guarded(m_bp, int'(pg_page)) != 0) ok = 0;
                if (ok != 0) begin
                    m_left = PROG;
                    if (sr_commit) begin
                        m_is_sr = 1; m_pend = int'(sr_bp);
                    end else begin
                        m_is_sr = 0; m_stb = 1; m_page = int'(pg_page);
                    end
                end else begin
                    m_wel = 0;
                end
            end else if (was_busy == 0) begin
                if (wen_clr) m_wel = 0;
                else if (wen_set) m_wel = 1;
            end
        end
    end

    task automatic check(string tag, int actual, int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R1 status byte", int'(status), 'hF0 | (m_bp << 2) | (m_wel << 1) | ((m_left > 0) ? 1 : 0));
            check("R3 busy", int'(busy), (m_left > 0) ? 1 : 0);
            check("R6 strobe", int'(arr_wr), m_stb);
            check("R6 page", int'(arr_page), m_page);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_set();
        wen_set = 1'b1; tick(); wen_set = 1'b0;
    endtask

    task automatic do_clr();
        wen_clr = 1'b1; tick(); wen_clr = 1'b0;
    endtask

    task automatic do_pg(int p);
        pg_commit = 1'b1; pg_page = PW'(p); tick(); pg_commit = 1'b0;
    endtask

    task automatic do_sr(int b);
        sr_commit = 1'b1; sr_bp = 2'(b); tick(); sr_commit = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            tick();
        end
    endtask

    task automatic set_code(int b);
        int n;
        do_set(); do_sr(b); wait_idle(n);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1 reset status", int'(status), 'hF0);
        check("R10 reset busy", int'(busy), 0);

        do_set();  check("R2 set latch", int'(status), 'hF2);
        do_clr();  check("R2 clear latch", int'(status), 'hF0);
        wen_set = 1'b1; wen_clr = 1'b1; tick(); wen_set = 1'b0; wen_clr = 1'b0;
        check("R2 clear wins", int'(status), 'hF0);

        do_set(); wp_n = 1'b0; do_pg(5); wp_n = 1'b1;
        check("R3 wp blocks busy", int'(busy), 0);
        check("R4 wp reject clears wel", int'(status), 'hF0);
        do_pg(6);
        check("R4 no wel strobe", int'(arr_wr), 0);
        check("R4 page kept", int'(arr_page), 0);

        do_set(); do_pg(5);
        check("R6 strobe after commit", int'(arr_wr), 1);
        check("R6 page out", int'(arr_page), 5);
        check("R3 busy status", int'(status), 'hF3);
        tick();
        check("R6 strobe one cycle", int'(arr_wr), 0);
        do_set();
        check("R2 set ignored busy", int'(status), 'hF3);
        do_pg(7);
        check("R4 busy reject clears wel", int'(status), 'hF1);
        check("R4 page unchanged", int'(arr_page), 5);
        wait_idle(n);

        do_set(); do_pg(9); n = 0;
        while (busy && n < 1000) begin n++; tick(); end
        check("R3 busy length", n, PROG);
        check("R8 wel after end", int'(status), 'hF0);

        do_set(); do_sr(1);
        check("R7 old code while busy", int'(status), 'hF3);
        tick();
        check("R7 still old code", int'(status[3:2]), 0);
        wait_idle(n);
        check("R7 new code visible", int'(status), 'hF4);

        do_set(); do_pg('h30);
        check("R5 01 blocks 300h", int'(busy), 0);
        do_set(); do_pg('h2F);
        check("R5 01 allows 2F0h", int'(arr_wr), 1);
        wait_idle(n);

        set_code(2);
        do_set(); do_pg('h20);
        check("R5 10 blocks 200h", int'(busy), 0);
        do_set(); do_pg('h1F);
        check("R5 10 allows 1F0h", int'(arr_wr), 1);
        wait_idle(n);

        set_code(3);
        do_set(); do_pg(0);
        check("R5 11 blocks 000h", int'(busy), 0);
        set_code(0);
        check("R5 status write under 11", int'(status), 'hF0);
        do_set(); do_pg('h3F);
        check("R5 00 allows 3F0h", int'(arr_wr), 1);
        wait_idle(n);

        do_set();
        sr_commit = 1'b1; sr_bp = 2'b10; pg_commit = 1'b1; pg_page = PW'(3);
        tick();
        sr_commit = 1'b0; pg_commit = 1'b0;
        check("R9 page dropped", int'(arr_wr), 0);
        check("R9 status taken", int'(busy), 1);
        wait_idle(n);
        check("R9 code written", int'(status), 'hF8);

        do_set();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
        check("R10 reset restores", int'(status), 'hF0);

        repeat (2) tick();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule